// File: doc/BRIEF.md
# Phase-Shifted Three-Phase Carrier PWM

This block produces the switch commands for one two-level, three-phase converter stage. Each of the three legs compares its duty reference against a triangular carrier of its own. The three carriers are taken from a single phase timebase at fixed offsets, a third of a turn apart. Running the three carriers 120 degrees apart moves the dominant first-band ripple current of the stage onto a single sideband. A run-time phase word can shift the whole carrier set, which lets an outer loop line this stage's ripple up in phase with the ripple of a second stage that shares the DC link.

The carrier rate is set by two step words that the block adds together: one for the chosen harmonic frequency (for example 7000 Hz, converted to accumulator counts per clock) and one for the measured AC fundamental. The dominant first-band component then falls on the chosen harmonic. A new rate or a new set-phase word is taken up only when the timebase wraps, so a carrier period never changes part way through. Each leg samples its signed reference twice per carrier period, at the top and at the bottom of its own triangle. A one-cycle strobe marks every timebase wrap for downstream sampling.

Top module: `tri_carrier_pwm`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next outputs are `gate_hi` = 000, `gate_lo` = 111 and `period_stb` = 0.
- R2: In every cycle outside reset, `gate_lo` is the bitwise inverse of `gate_hi`.
- R3: A W-bit timebase (W = `ACC_W`) advances by the active step on every clock. `period_stb` is high for exactly one cycle, in the cycle after each clock at which the timebase passes through zero. With a constant step S that divides 2^W, strobes are 2^W/S cycles apart. The step must stay below half a turn.
- R4: The step taken up at a wrap is `harm_step + fund_step`, modulo 2^W. During reset the step is loaded from the same sum.
- R5: A change of `harm_step` or `fund_step` does not alter the carrier period in progress. The new step applies from the first clock after the next wrap.
- R6: Leg phases are A = timebase + active set-phase, B = A + 21845 and C = A + 43691, modulo 2^16 at the default width: B leads A by one third of a turn and C lags A by one third of a turn. Bit k of `gate_hi` and byte k of `duty_ref` belong to leg k (0 = A, 1 = B, 2 = C).
- R7: `set_phase` is taken up only at a wrap, and it moves all three leg phases by the same amount.
- R8: A leg's carrier is phase bits [W-2 : W-1-`CAR_W`] while the phase MSB is 0 (rising), and the inverse of those bits while the MSB is 1 (falling). A leg samples its reference on every clock at which its phase MSB differs from the value it held at the previous clock, i.e. at each carrier peak and valley. Reference changes at other clocks have no effect.
- R9: A reference is a two's-complement byte whose level is the reference with the sign bit inverted. `gate_hi[k]` is high in the cycle after the clock at which the sampled level is strictly greater than the carrier. A reference of -128 therefore keeps the gate low. A reference of +127 drops the gate only while the carrier is at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| harm_step | input | ACC_W | Timebase step for the target harmonic frequency |
| fund_step | input | ACC_W | Timebase step for the measured AC fundamental |
| set_phase | input | ACC_W | Phase offset for the whole carrier set |
| duty_ref | input | 3*CAR_W | Signed duty references, leg A in the low byte |
| gate_hi | output | 3 | Upper-switch commands, one per leg |
| gate_lo | output | 3 | Lower-switch commands, inverse of `gate_hi` |
| period_stb | output | 1 | One-cycle pulse at each timebase wrap |

## Verification
The checker watches these properties on every clock: the reset state, the exact complement of the two gate vectors, the single-cycle width of the strobe, the rule that the active step and set-phase change only together with a strobe, and the rule that a zero sampled level keeps its gate low. What the bench alone can show is that the waveforms are right: the 120-degree spread between legs, sampling at both peak and valley while references change on every clock, and a rate change that leaves the running period at its old length. It shows this by sweeping every reference code and several step values against a cycle-level model computed from the requirements, and by measuring strobe spacing and gate high-time counts.

// File: rtl/tcp_pkg.sv
// Shared constants and helpers for the phase-shifted three-phase carrier PWM.
// Assumes the accumulator width stays below 31 bits so one turn fits in an int.
package tcp_pkg;

    localparam int NUM_LEGS = 3;

    // Phase word offset of a leg, relative to leg A: 0, +1/3 turn, -1/3 turn (rounded)
    function automatic int unsigned leg_offset(input int leg, input int acc_w);
        int unsigned turn;
        int unsigned third;
        turn  = 32'd1 << acc_w;
        third = (turn + 32'd1) / 32'd3;
        case (leg)
            0:       return 32'd0;
            1:       return third;
            default: return turn - third;
        endcase
    endfunction

endpackage

// File: rtl/tcp_timebase.sv
// Shared phase timebase: a W-bit accumulator plus shadowed step and set-phase.
// A new step (harmonic + fundamental) or set-phase is taken up only when the
// accumulator wraps, so a carrier period never changes part way through.
// Assumes the step stays below half a turn.
module tcp_timebase #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] harm_step,
    input  logic [ACC_W-1:0] fund_step,
    input  logic [ACC_W-1:0] set_phase,
    output logic [ACC_W-1:0] frame_phase,
    output logic [ACC_W-1:0] inc_act,
    output logic [ACC_W-1:0] ref_act,
    output logic             period_stb
);

    logic [ACC_W-1:0] acc;
    logic [ACC_W:0]   sum;
    logic [ACC_W-1:0] req_step;
    logic             wrap;

    // Next accumulator value, its carry, and the requested step
    always_comb begin
        sum      = {1'b0, acc} + {1'b0, inc_act};
        wrap     = sum[ACC_W];
        req_step = harm_step + fund_step;
    end

    // Phase of the whole carrier set before the per-leg offsets
    assign frame_phase = acc + ref_act;

    // Advance the timebase; load the shadowed words only at a wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc        <= '0;
            inc_act    <= req_step;
            ref_act    <= set_phase;
            period_stb <= 1'b0;
        end else begin
            acc        <= sum[ACC_W-1:0];
            period_stb <= wrap;
            if (wrap) begin
                inc_act <= req_step;
                ref_act <= set_phase;
            end
        end
    end

endmodule

// File: rtl/tcp_leg.sv
// One converter leg: triangular carrier at a fixed offset from the frame
// phase, sampling of the reference at each peak and valley, and the comparator.
// Assumes the step stays below half a turn, so every carrier peak and valley
// shows up as one change of the phase MSB.
module tcp_leg
    import tcp_pkg::*;
#(
    parameter int ACC_W = 16,
    parameter int CAR_W = 8,
    parameter int LEG   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] frame_phase,
    input  logic [CAR_W-1:0] duty,
    output logic             gate_p,
    output logic             gate_n,
    output logic [CAR_W-1:0] samp_lvl
);

    localparam logic [ACC_W-1:0] OFFSET = ACC_W'(leg_offset(LEG, ACC_W));
    localparam int               TOP    = ACC_W - 1;
    localparam int               SHIFT  = ACC_W - 1 - CAR_W;

    logic [ACC_W-1:0] leg_ph;
    logic [CAR_W-1:0] ramp;
    logic [CAR_W-1:0] carrier;
    logic [CAR_W-1:0] level;
    logic             half_prev;
    logic             turn_pt;

    // Leg phase, triangle carrier, offset-binary level and the peak/valley event
    always_comb begin
        leg_ph  = frame_phase + OFFSET;
        ramp    = CAR_W'(leg_ph >> SHIFT);
        carrier = leg_ph[TOP] ? ~ramp : ramp;
        level   = {~duty[CAR_W-1], duty[CAR_W-2:0]};
        turn_pt = leg_ph[TOP] ^ half_prev;
    end

    // Asymmetric regular sampling: capture the reference at peak and valley
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_prev <= 1'b0;
            samp_lvl  <= '0;
        end else begin
            half_prev <= leg_ph[TOP];
            if (turn_pt) begin
                samp_lvl <= level;
            end
        end
    end

    // Registered comparator driving the complementary switch pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_p <= 1'b0;
            gate_n <= 1'b1;
        end else begin
            gate_p <= (samp_lvl > carrier);
            gate_n <= ~(samp_lvl > carrier);
        end
    end

endmodule

// File: rtl/tri_carrier_pwm.sv
// Top level: one shared timebase feeding three legs whose carriers sit at
// 0, +120 and -120 degrees. Leg k uses bit k of the gate vectors and byte k
// of the reference bus.
module tri_carrier_pwm
    import tcp_pkg::*;
#(
    parameter int ACC_W = 16,
    parameter int CAR_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ACC_W-1:0]          harm_step,
    input  logic [ACC_W-1:0]          fund_step,
    input  logic [ACC_W-1:0]          set_phase,
    input  logic [NUM_LEGS*CAR_W-1:0] duty_ref,
    output logic [NUM_LEGS-1:0]       gate_hi,
    output logic [NUM_LEGS-1:0]       gate_lo,
    output logic                      period_stb
);

    logic [ACC_W-1:0]          frame_phase;
    logic [ACC_W-1:0]          inc_act;
    logic [ACC_W-1:0]          ref_act;
    logic [NUM_LEGS*CAR_W-1:0] samp_flat;

    tcp_timebase #(
        .ACC_W(ACC_W)
    ) u_timebase (
        .clk        (clk),
        .rst_n      (rst_n),
        .harm_step  (harm_step),
        .fund_step  (fund_step),
        .set_phase  (set_phase),
        .frame_phase(frame_phase),
        .inc_act    (inc_act),
        .ref_act    (ref_act),
        .period_stb (period_stb)
    );

    for (genvar k = 0; k < NUM_LEGS; k++) begin : g_leg
        tcp_leg #(
            .ACC_W(ACC_W),
            .CAR_W(CAR_W),
            .LEG  (k)
        ) u_leg (
            .clk        (clk),
            .rst_n      (rst_n),
            .frame_phase(frame_phase),
            .duty       (duty_ref[k*CAR_W +: CAR_W]),
            .gate_p     (gate_hi[k]),
            .gate_n     (gate_lo[k]),
            .samp_lvl   (samp_flat[k*CAR_W +: CAR_W])
        );
    end

endmodule

// File: rtl/tcp_checker.sv
// Cycle-by-cycle properties of the carrier PWM, bound to the top module.
// Assumes the bench keeps the step below half a turn, as the block requires.
module tcp_checker
    import tcp_pkg::*;
#(
    parameter int ACC_W = 16,
    parameter int CAR_W = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_LEGS-1:0]       gate_hi,
    input logic [NUM_LEGS-1:0]       gate_lo,
    input logic                      period_stb,
    input logic [ACC_W-1:0]          inc_act,
    input logic [ACC_W-1:0]          ref_act,
    input logic [NUM_LEGS*CAR_W-1:0] samp_flat
);

    localparam logic [ACC_W-1:0] HALF = {1'b1, {(ACC_W-1){1'b0}}};

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (gate_hi == '0 && gate_lo == '1 && !period_stb));

    // R2
    complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_lo == ~gate_hi);

    // R3
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period_stb && inc_act < HALF && $past(inc_act) < HALF) |=> !period_stb);

    // R5
    step_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && inc_act != $past(inc_act)) |-> period_stb);

    // R7
    shift_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ref_act != $past(ref_act)) |-> period_stb);

    for (genvar k = 0; k < NUM_LEGS; k++) begin : g_leg_chk
        // R9
        floor_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (samp_flat[k*CAR_W +: CAR_W] == '0) |=> !gate_hi[k]);
    end

endmodule

bind tri_carrier_pwm tcp_checker #(
    .ACC_W(ACC_W),
    .CAR_W(CAR_W)
) u_tcp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate_hi   (gate_hi),
    .gate_lo   (gate_lo),
    .period_stb(period_stb),
    .inc_act   (inc_act),
    .ref_act   (ref_act),
    .samp_flat (samp_flat)
);

// File: tb/test_tri_carrier_pwm.sv
`timescale 1ns/1ps
// Self-checking bench: a cycle-level model built from the requirements runs
// alongside the design, plus explicit strobe-spacing and high-time checks.
module test_tri_carrier_pwm;

    localparam int AW = 16;
    localparam int CW = 8;
    localparam int NL = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [AW-1:0]     harm_step = '0;
    logic [AW-1:0]     fund_step = '0;
    logic [AW-1:0]     set_phase = '0;
    logic [NL*CW-1:0]  duty_ref = '0;
    logic [NL-1:0]     gate_hi;
    logic [NL-1:0]     gate_lo;
    logic              period_stb;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int last_stb = 0;
    int last_gap = 0;
    int cnt_a = 0;
    int cnt_b = 0;
    bit done = 1'b0;

    // model state
    logic [AW-1:0] m_acc, m_inc, m_ref;
    logic [NL-1:0] m_hp, m_gate;
    logic [CW-1:0] m_s [NL];
    logic          m_stb;

    tri_carrier_pwm #(.ACC_W(AW), .CAR_W(CW)) i_tri_carrier_pwm (
        .clk(clk), .rst_n(rst_n), .harm_step(harm_step), .fund_step(fund_step),
        .set_phase(set_phase), .duty_ref(duty_ref), .gate_hi(gate_hi),
        .gate_lo(gate_lo), .period_stb(period_stb)
    );

    always #2.5 clk = ~clk;

    // R6: per-leg phase offsets at the default width
    function automatic logic [AW-1:0] leg_off(input int k);
        case (k)
            0:       return 16'd0;
            1:       return 16'd21845;
            default: return 16'd43691;
        endcase
    endfunction

    task automatic check_val(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic model_reset();
        m_acc = '0;
        m_inc = harm_step + fund_step;
        m_ref = set_phase;
        m_hp = '0;
        m_gate = '0;
        m_stb = 1'b0;
        for (int k = 0; k < NL; k++) m_s[k] = '0;
    endtask

    // Next model state from the inputs seen at the coming clock edge
    task automatic model_step();
        logic [AW-1:0] ph;
        logic [CW-1:0] c, d, lv;
        logic [AW:0]   s;
        logic [NL-1:0] g_n, hp_n;
        logic [CW-1:0] s_n [NL];
        for (int k = 0; k < NL; k++) begin
            ph = m_acc + m_ref + leg_off(k);                  // R6 R7
            c = ph[AW-1] ? ~ph[AW-2:AW-1-CW] : ph[AW-2:AW-1-CW]; // R8
            d = duty_ref[k*CW +: CW];
            lv = {~d[CW-1], d[CW-2:0]};                       // R9
            g_n[k] = m_s[k] > c;
            hp_n[k] = ph[AW-1];
            s_n[k] = (ph[AW-1] != m_hp[k]) ? lv : m_s[k];     // R8
        end
        s = {1'b0, m_acc} + {1'b0, m_inc};                    // R3
        if (s[AW]) begin
            m_inc = harm_step + fund_step;                    // R4 R5
            m_ref = set_phase;                                // R7
        end
        m_acc = s[AW-1:0];
        m_stb = s[AW];
        m_gate = g_n;
        m_hp = hp_n;
        for (int k = 0; k < NL; k++) m_s[k] = s_n[k];
    endtask

    // One clock: step the model, then compare at the falling edge
    task automatic cycle();
        model_step();
        @(posedge clk);
        @(negedge clk);
        cyc++;
        nchk++;
        if (gate_hi !== m_gate || gate_lo !== ~m_gate) begin
            nfail++;
            $display("FAIL R2 R6 R7 R8 R9 cycle %0d: gate_hi=%b gate_lo=%b expected %b %b",
                     cyc, gate_hi, gate_lo, m_gate, ~m_gate);
        end
        nchk++;
        if (period_stb !== m_stb) begin
            nfail++;
            $display("FAIL R3 cycle %0d: period_stb=%b expected %b", cyc, period_stb, m_stb);
        end
        if (period_stb) begin
            last_gap = cyc - last_stb;
            last_stb = cyc;
        end
        if (gate_hi[0]) cnt_a++;
        if (gate_hi[1]) cnt_b++;
    endtask

    task automatic wait_strobe();
        do cycle(); while (!period_stb);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: run did not complete, actual hung expected finish");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        harm_step = 16'd200;
        fund_step = 16'd56;
        set_phase = 16'd0;
        duty_ref = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        model_reset();
        // R1: reset state
        check_val("R1 gate_hi", int'(gate_hi), 0);
        check_val("R1 gate_lo", int'(gate_lo), 7);
        check_val("R1 period_stb", int'(period_stb), 0);
        rst_n = 1'b1;

        // S1: step 200+56 = 256, strobes every 256 cycles (R3 R4)
        repeat (3) wait_strobe();
        check_val("R3 R4 strobe spacing", last_gap, 256);

        // S2: extreme references (R9)
        duty_ref = {8'sd64, 8'sd127, -8'sd128};
        run(300);
        cnt_a = 0;
        cnt_b = 0;
        run(512);
        check_val("R9 leg A at -128 high count", cnt_a, 0);
        check_val("R9 leg B at +127 high count", cnt_b, 510);

        // S3: references changing on every clock, only peaks/valleys count (R8)
        for (int i = 0; i < 1024; i++) begin
            duty_ref = {8'(i * 13), 8'(i * 91 + 5), 8'(i * 37)};
            cycle();
        end

        // S4: rate change mid-period (R5)
        wait_strobe();
        run(100);
        harm_step = 16'd456;  // step becomes 512
        wait_strobe();
        check_val("R5 period in progress keeps old length", last_gap, 256);
        wait_strobe();
        check_val("R4 R5 new step after wrap", last_gap, 128);

        // S5: whole-set phase shift mid-period (R7)
        run(40);
        set_phase = 16'h4000;
        duty_ref = {8'sd30, -8'sd70, 8'sd100};
        run(600);
        set_phase = 16'hC123;
        for (int i = 0; i < 600; i++) begin
            duty_ref = {8'(i * 7), 8'(i * 29 + 100), 8'(i * 53)};
            cycle();
        end

        // S6: step sweep, each spacing checked after settling (R3 R4)
        for (int j = 0; j < 4; j++) begin
            int stp;
            stp = (j == 0) ? 128 : (j == 1) ? 1024 : (j == 2) ? 2048 : 64;
            fund_step = 16'd24;
            harm_step = 16'(stp - 24);
            duty_ref = {8'(j * 60 + 1), 8'(j * 33 + 90), 8'(200 - j * 45)};
            repeat (3) wait_strobe();
            check_val("R3 R4 swept step spacing", last_gap, 65536 / stp);
        end

        // S7: every reference code on all legs at step 2048 (R6 R8 R9)
        fund_step = 16'd48;
        harm_step = 16'd2000;
        repeat (2) wait_strobe();
        for (int v = 0; v < 256; v++) begin
            duty_ref = {8'(v + 85), 8'(255 - v), 8'(v)};
            run(32);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule